// File: doc/BRIEF.md
# Minimal 8-bit Accumulator CPU

A small multi-cycle computer built around one 8-bit accumulator. A 16-byte RAM holds both program and data. Every instruction is a single byte: the high nibble selects the operation and the low nibble is either a RAM address or a 4-bit immediate. A step counter walks each instruction through two fetch steps and up to three execute steps. An add/subtract unit updates carry and zero flags, and conditional jumps test those flags.

To program the CPU, a host holds it in load mode and writes bytes through a simple address/data port. While load mode is held, execution is suspended. After load mode drops and reset is released, the CPU runs from address 0. It shows results through an 8-bit output register and raises a halt indicator when it meets a halt instruction.

Top module: `acc8_cpu`

## Requirements
- R1: Reset clears the program counter, accumulator, flags, step counter and output register. After reset `out_value` is 0x00 and `halted` is 0.
- R2: Every instruction has the same two fetch steps. The first loads the program counter into the address register. The second loads the addressed byte into the instruction register and increments the 4-bit program counter, which wraps from 15 to 0. The instruction byte is laid out as opcode in bits 7:4 and operand in bits 3:0.
- R3: Opcode 0x1 loads the accumulator from RAM[operand]. Opcode 0x5 writes the accumulator to RAM[operand]. Opcode 0x9 copies the accumulator into `out_value`. `out_value` changes on no other instruction.
- R4: Opcode 0x2 adds RAM[operand] to the accumulator and opcode 0x7 subtracts it, both modulo 256.
- R5: Opcode 0x6 adds, and opcode 0x8 subtracts, the operand nibble zero-extended to 8 bits.
- R6: Each arithmetic instruction sets zero when the 8-bit result is 0x00. For an add, carry is the carry out of bit 7. For a subtract, carry is set exactly when the minuend is less than the subtrahend (a borrow).
- R7: The flags change only on opcodes 0x2, 0x6, 0x7 and 0x8. Every other instruction leaves them as they were.
- R8: Opcode 0x3 always loads the program counter with the operand. Opcode 0x4 does so only when carry is set, and opcode 0xA only when zero is set. Otherwise execution continues with the next byte.
- R9: Opcode 0xB sets `halted`. The program counter, accumulator and output then stay frozen until reset.
- R10: While `load_mode` is 1, `load_data` is written to RAM[`load_addr`] on each clock edge where `load_we` is 1. The step counter is held at 0 and no instruction executes.
- R11: Opcodes 0x0 and 0xC to 0xF do nothing beyond fetch. Execution continues with the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_mode | input | 1 | Suspends execution and enables the programming port |
| load_we | input | 1 | Write strobe for the programming port |
| load_addr | input | 4 | RAM address to program |
| load_data | input | 8 | Byte to program |
| out_value | output | 8 | Output register written by the output instruction |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
`out_value` takes the accumulator at the clock edge that ends the third step of the output instruction. `halted` rises at the edge that ends the third step of the halt instruction. Jumps and no-ops take three steps, load, store and immediate arithmetic take four, and arithmetic from RAM takes five. Rather than counting cycles per program, the bench polls `halted` on falling clock edges and reads `out_value` only once `halted` has risen, when the output is frozen. The freeze check waits another twenty cycles. The load-mode check samples the outputs while the CPU is held, before load mode is released.

// File: rtl/acc8_cpu.sv
module acc8_cpu #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_mode,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] out_value,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam int OPW   = DW - AW;

  localparam logic [OPW-1:0] OP_LDA = 4'h1;
  localparam logic [OPW-1:0] OP_ADD = 4'h2;
  localparam logic [OPW-1:0] OP_JMP = 4'h3;
  localparam logic [OPW-1:0] OP_JC  = 4'h4;
  localparam logic [OPW-1:0] OP_STA = 4'h5;
  localparam logic [OPW-1:0] OP_ADI = 4'h6;
  localparam logic [OPW-1:0] OP_SUB = 4'h7;
  localparam logic [OPW-1:0] OP_SUI = 4'h8;
  localparam logic [OPW-1:0] OP_OUT = 4'h9;
  localparam logic [OPW-1:0] OP_JZ  = 4'hA;
  localparam logic [OPW-1:0] OP_HLT = 4'hB;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ir, acc, breg;
  logic          cf, zf;
  logic [2:0]    step;

  wire [OPW-1:0] opc    = ir[DW-1:AW];
  wire [AW-1:0]  arg    = ir[AW-1:0];
  wire [DW-1:0]  rd     = mem[mar];
  wire           run    = !load_mode && !halted;
  wire           is_sub = (opc == OP_SUB) || (opc == OP_SUI);
  wire [DW:0]    sum    = is_sub ? ({1'b0, acc} - {1'b0, breg})
                                 : ({1'b0, acc} + {1'b0, breg});

  always_ff @(posedge clk) begin
    if (load_mode && load_we)
      mem[load_addr] <= load_data;
    else if (run && step == 3'd3 && opc == OP_STA)
      mem[mar] <= acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; ir <= '0; acc <= '0; breg <= '0;
      cf <= 1'b0; zf <= 1'b0; step <= '0;
      out_value <= '0; halted <= 1'b0;
    end else if (load_mode) begin
      step <= '0;
    end else if (!halted) begin
      step <= step + 3'd1;
      case (step)
        3'd0: mar <= pc;
        3'd1: begin
          ir <= rd;
          pc <= pc + 1'b1;
        end
        3'd2: begin
          case (opc)
            OP_LDA, OP_ADD, OP_SUB, OP_STA: mar <= arg;
            OP_ADI, OP_SUI: breg <= {{OPW{1'b0}}, arg};
            OP_JMP: begin pc <= arg; step <= '0; end
            OP_JC:  begin if (cf) pc <= arg; step <= '0; end
            OP_JZ:  begin if (zf) pc <= arg; step <= '0; end
            OP_OUT: begin out_value <= acc; step <= '0; end
            OP_HLT: begin halted <= 1'b1; step <= step; end
            default: step <= '0;
          endcase
        end
        3'd3: begin
          case (opc)
            OP_LDA: begin acc <= rd; step <= '0; end
            OP_ADD, OP_SUB: breg <= rd;
            OP_ADI, OP_SUI: begin
              acc  <= sum[DW-1:0];
              cf   <= sum[DW];
              zf   <= (sum[DW-1:0] == '0);
              step <= '0;
            end
            default: step <= '0;
          endcase
        end
        3'd4: begin
          acc  <= sum[DW-1:0];
          cf   <= sum[DW];
          zf   <= (sum[DW-1:0] == '0);
          step <= '0;
        end
        default: step <= '0;
      endcase
    end
  end

  // R2: fetch increments the program counter by one, wrapping
  a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == 3'd1) |=> (pc == $past(pc) + 1'b1));
  // R2: step counter never passes the last execute step
  a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd4);
  // R3: output register moves only on the output instruction
  a_r3_out_only_on_out: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && step == 3'd2 && opc == OP_OUT) |=> $stable(out_value));
  // R6: subtraction sets carry exactly on borrow
  a_r6_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == 3'd4 && opc == OP_SUB) |=> (cf == ($past(acc) < $past(breg))));
  // R7: fetch and address steps never touch the flags
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step != 3'd3 && step != 3'd4) |=> $stable({cf, zf}));
  // R9: halt freezes state until reset
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(out_value)));
  // R10: load mode suspends execution
  a_r10_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> (step == 3'd0 && $stable(pc) && $stable(acc) && $stable(out_value)));
endmodule

// File: tb/tb_acc8_cpu.sv
module tb_acc8_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_mode = 1'b0;
  logic       load_we = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  wire  [7:0] out_value;
  wire        halted;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] img [16];

  always #5 clk = ~clk;

  acc8_cpu dut (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .load_we(load_we),
    .load_addr(load_addr), .load_data(load_data),
    .out_value(out_value), .halted(halted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_img;
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  task automatic write_img;
    rst_n = 1'b0;
    load_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_we = 1'b1;
      load_addr = 4'(i);
      load_data = img[i];
    end
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic start_cpu;
    load_mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt;
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_img;
    write_img();
    start_cpu();
    wait_halt();
  endtask

  function automatic logic [9:0] alu_ref(input logic [7:0] a, input logic [7:0] b, input bit sub);
    logic [8:0] r;
    logic c;
    if (sub) begin
      r = {1'b0, a} - {1'b0, b};
      c = (a < b);
    end else begin
      r = {1'b0, a} + {1'b0, b};
      c = r[8];
    end
    return {c, (r[7:0] == 8'h00), r[7:0]};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, opnd;
    logic [9:0] ref_v;
    int mode;
    void'($urandom(32'd1234));

    // R1 reset state and R2 fetch via simple program
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h90; img[2] = 8'hB0; img[14] = 8'h3C;
    write_img();
    start_cpu();
    check("R1 out after reset", out_value, 8'h00);
    check("R1 halted after reset", halted, 1'b0);
    wait_halt();
    check("R3 lda/out", out_value, 8'h3C);

    // R10 load mode holds execution with reset released
    write_img();
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R10 out held in load mode", out_value, 8'h00);
    check("R10 not halted in load mode", halted, 1'b0);
    load_mode = 1'b0;
    wait_halt();
    check("R10 runs after load mode", out_value, 8'h3C);

    // R4 R8 multiply 5 x 8 by repeated addition
    clear_img();
    img[0] = 8'h1C; img[1] = 8'h2F; img[2] = 8'h5C; img[3] = 8'h1E;
    img[4] = 8'h81; img[5] = 8'h5E; img[6] = 8'hA8; img[7] = 8'h30;
    img[8] = 8'h1C; img[9] = 8'h90; img[10] = 8'hB0;
    img[12] = 8'h00; img[14] = 8'd5; img[15] = 8'd8;
    run_img();
    check("R4 R8 multiply halted", halted, 1'b1);
    check("R4 R8 multiply product", out_value, 8'd40);

    // R6 R8 divide 45 / 6 by repeated subtraction
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h7F; img[2] = 8'h48; img[3] = 8'h5E;
    img[4] = 8'h1D; img[5] = 8'h61; img[6] = 8'h5D; img[7] = 8'h30;
    img[8] = 8'h1D; img[9] = 8'h90; img[10] = 8'hB0;
    img[13] = 8'd0; img[14] = 8'd45; img[15] = 8'd6;
    run_img();
    check("R6 R8 divide quotient", out_value, 8'd7);

    // R7 carry survives a load
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h7F; img[2] = 8'h1D; img[3] = 8'h45;
    img[4] = 8'hB0; img[5] = 8'h90; img[6] = 8'hB0;
    img[13] = 8'h5A; img[14] = 8'd2; img[15] = 8'd9;
    run_img();
    check("R7 flags kept across load", out_value, 8'h5A);

    // R3 store then reload
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h5D; img[2] = 8'h1F; img[3] = 8'h1D;
    img[4] = 8'h90; img[5] = 8'hB0;
    img[13] = 8'h00; img[14] = 8'h77; img[15] = 8'h11;
    run_img();
    check("R3 store reload", out_value, 8'h77);

    // R11 unused opcodes are no-ops
    clear_img();
    img[0] = 8'h1E; img[1] = 8'hC5; img[2] = 8'hD7; img[3] = 8'hE1;
    img[4] = 8'hF3; img[5] = 8'h0E; img[6] = 8'h90; img[7] = 8'hB0;
    img[14] = 8'h6B;
    run_img();
    check("R11 unused opcodes", out_value, 8'h6B);

    // R2 program counter wraps from 15 to 0
    clear_img();
    img[0] = 8'h46; img[1] = 8'h1F; img[2] = 8'h2F; img[3] = 8'h3E;
    img[6] = 8'hB0; img[14] = 8'h90; img[15] = 8'hC0;
    run_img();
    check("R2 pc wrap halted", halted, 1'b1);
    check("R2 pc wrap out", out_value, 8'h80);

    // R9 halt freezes output
    clear_img();
    img[0] = 8'h1E; img[1] = 8'h90; img[2] = 8'hB0; img[3] = 8'h1F;
    img[4] = 8'h90; img[5] = 8'hB0; img[14] = 8'h21; img[15] = 8'h99;
    run_img();
    repeat (20) @(negedge clk);
    check("R9 halted stays", halted, 1'b1);
    check("R9 output frozen", out_value, 8'h21);

    // R4 R5 R6 R8 random and corner arithmetic
    for (int k = 0; k < 40; k++) begin
      a = 8'($urandom);
      b = 8'($urandom);
      mode = int'($urandom % 4);
      if (k == 0) begin a = 8'hFF; b = 8'h01; mode = 0; end
      if (k == 1) begin a = 8'h05; b = 8'h05; mode = 1; end
      if (k == 2) begin a = 8'h03; b = 8'h06; mode = 1; end
      if (k == 3) begin a = 8'hFF; b = 8'h0F; mode = 2; end
      if (k == 4) begin a = 8'h00; b = 8'h01; mode = 3; end
      opnd = (mode >= 2) ? {4'h0, b[3:0]} : b;
      ref_v = alu_ref(a, opnd, (mode == 1) || (mode == 3));
      for (int f = 0; f < 2; f++) begin
        clear_img();
        img[0] = 8'h1E;
        case (mode)
          0: img[1] = 8'h2F;
          1: img[1] = 8'h7F;
          2: img[1] = {4'h6, b[3:0]};
          default: img[1] = {4'h8, b[3:0]};
        endcase
        img[2] = 8'h90;
        img[3] = (f == 0) ? 8'h46 : 8'hA6;
        img[4] = 8'hB0; img[6] = 8'h1D; img[7] = 8'h90; img[8] = 8'hB0;
        img[13] = 8'hA5; img[14] = a; img[15] = b;
        run_img();
        if (f == 0)
          check((mode < 2) ? "R4 R6 carry path" : "R5 R6 carry path",
                out_value, ref_v[9] ? 8'hA5 : ref_v[7:0]);
        else
          check((mode < 2) ? "R4 R6 zero path" : "R5 R6 zero path",
                out_value, ref_v[8] ? 8'hA5 : ref_v[7:0]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule